// File: doc/BRIEF.md
# Isochronous Audio Packet Header and Timestamp Generator

This block builds the two-quadlet common isochronous packet header for every outgoing audio packet of a streaming transmitter. A packet builder pulses a start strobe together with the number of audio events the packet will carry. One cycle later the block returns both header quadlets and the payload length in bytes, together with a one-cycle valid strobe. Between packets the block keeps the running data block counter and the presentation timestamp state.

A configuration write selects one of seven sample rates and the number of channels per event. The rate sets the format-dependent field, the timestamp interval and the tick step. The timestamp runs on a 24.576 MHz tick count that wraps into a bus cycle count every 3072 ticks. It advances by an exact fraction, using a remainder register compared against the sample rate, so no divider is needed. Only packets that carry an event whose index is a multiple of the timestamp interval get a real timestamp. All other packets carry the no-info value.

Top module: `cip_hdr_gen`

## Requirements
- R1: `hdr_valid_o` is high in exactly the cycle after each cycle with `pkt_start_i` high, and low otherwise. Header outputs are updated on those edges only.
- R2: Header quadlet 0 has bits [31:30]=00, [29:24]=`node_id_i`, [23:16]=configured dimension, [15:8]=0 and [7:0]=data block counter before this packet.
- R3: Header quadlet 1 has bits [31:30]=10, [29:24]=0x10, [23:16]=configured rate code and [15:0]=timestamp.
- R4: Rate codes are 0=32k, 1=44.1k, 2=48k, 3=88.2k, 4=96k, 5=176.4k and 6=192k. The timestamp interval is 8 for codes 0-2, 16 for codes 3-4 and 32 for codes 5-6. A configuration write with code 7 is ignored: the rate, dimension and timestamp state are unchanged.
- R5: A packet is stamped when ((interval - dbc) & (interval - 1)) < event count. Otherwise bits [15:0] of quadlet 1 are 0xFFFF.
- R6: A stamp equals {cycle count mod 16, offset integer (12 bits)}. After each stamp the offset advances by 24,576,000 × interval / rate, with the fractional remainder carried exactly. The integer part is kept below 3072, and each wrap adds one to the cycle count.
- R7: Synchronous active-low reset clears the data block counter, sets the cycle count to 2, the offset to 2856 with zero remainder, and the configuration to rate code 2 with dimension 2. It also drops `hdr_valid_o`.
- R8: The data block counter advances by the event count mod 256 after each packet. `pkt_bytes_o` = (events × dimension + 2) × 4.
- R9: A valid configuration write reloads the cycle count and offset to their reset values and leaves the data block counter unchanged. The new settings apply to packets started in later cycles.
- R10: When a configuration write and a packet start fall in the same cycle, the header uses the old configuration and the old timestamp state. The timestamp state is then reloaded (that packet's advance is dropped), and the data block counter still advances.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| cfg_load_i | input | 1 | Configuration write strobe |
| cfg_code_i | input | 3 | Sample-rate code for the write |
| cfg_dim_i | input | 8 | Channels per event for the write |
| node_id_i | input | 6 | Source node ID, sampled with the start strobe |
| pkt_start_i | input | 1 | Start of one packet header |
| pkt_events_i | input | EVT_W | Events carried by the packet |
| hdr_valid_o | output | 1 | Header outputs are new this cycle |
| hdr_q0_o | output | 32 | First header quadlet |
| hdr_q1_o | output | 32 | Second header quadlet |
| pkt_bytes_o | output | EVT_W+11 | Payload size in bytes |

## Verification
Two things can land on the same edge: a configuration write, which reloads the timestamp state and swaps the rate, and a packet start, which would advance that same state and read the old rate. The bench drives both strobes in one cycle, and also places writes just before and just after packets. A behavioural model applies the header first and the reload second, then compares the header and every later timestamp on each clock. Long runs at 44.1 kHz and at mixed rates exercise the fractional remainder carry and the wrap at 3072 ticks.

// File: rtl/cip_pkg.sv
package cip_pkg;
    localparam int unsigned RATE_CODES      = 7;
    localparam int unsigned TICK_HZ         = 24576000;
    localparam int unsigned TICKS_PER_CYCLE = 3072;
    localparam int unsigned LAUNCH_DELAY    = 9000;
    localparam int unsigned INIT_CYCLE      = LAUNCH_DELAY / TICKS_PER_CYCLE;
    localparam int unsigned INIT_OFFSET     = LAUNCH_DELAY % TICKS_PER_CYCLE;

    localparam int CODE_W = 3;
    localparam int SID_W  = 6;
    localparam int DIM_W  = 8;
    localparam int DBC_W  = 8;
    localparam int CYC_W  = 4;
    localparam int OFF_W  = 12;
    localparam int STEP_W = 13;
    localparam int REM_W  = 18;
    localparam int IVL_W  = 6;

    localparam logic [1:0]        EOH_FIRST    = 2'b00;
    localparam logic [1:0]        EOH_SECOND   = 2'b10;
    localparam logic [5:0]        FMT_AUDIO    = 6'h10;
    localparam logic [CODE_W-1:0] DEFAULT_CODE = 3'd2;
    localparam logic [DIM_W-1:0]  DEFAULT_DIM  = 8'd2;

    function automatic int unsigned code_rate_hz(input int unsigned c);
        case (c)
            0:       return 32000;
            1:       return 44100;
            3:       return 88200;
            4:       return 96000;
            5:       return 176400;
            6:       return 192000;
            default: return 48000;
        endcase
    endfunction

    function automatic int unsigned code_interval(input int unsigned c);
        if (c >= 5 && c < RATE_CODES) return 32;
        if (c == 3 || c == 4)         return 16;
        return 8;
    endfunction
endpackage

// File: rtl/cip_rate_table.sv
module cip_rate_table
    import cip_pkg::*;
(
    input  logic [CODE_W-1:0] code_i,
    output logic [IVL_W-1:0]  ivl_o,
    output logic [STEP_W-1:0] step_int_o,
    output logic [REM_W-1:0]  step_rem_o,
    output logic [REM_W-1:0]  rate_o
);
    localparam int unsigned ENTRIES = 1 << CODE_W;

    logic [IVL_W-1:0]  ivl_tab  [ENTRIES];
    logic [STEP_W-1:0] sint_tab [ENTRIES];
    logic [REM_W-1:0]  srem_tab [ENTRIES];
    logic [REM_W-1:0]  rate_tab [ENTRIES];

    for (genvar c = 0; c < ENTRIES; c++) begin : g_code
        localparam int unsigned EC  = (c < RATE_CODES) ? c : DEFAULT_CODE;
        localparam int unsigned IVL = code_interval(EC);
        localparam int unsigned HZ  = code_rate_hz(EC);
        localparam int unsigned NUM = TICK_HZ * IVL;
        assign ivl_tab[c]  = IVL_W'(IVL);
        assign sint_tab[c] = STEP_W'(NUM / HZ);
        assign srem_tab[c] = REM_W'(NUM % HZ);
        assign rate_tab[c] = REM_W'(HZ);
    end

    always_comb begin
        ivl_o      = ivl_tab[code_i];
        step_int_o = sint_tab[code_i];
        step_rem_o = srem_tab[code_i];
        rate_o     = rate_tab[code_i];
    end
endmodule

// File: rtl/cip_syt_accum.sv
module cip_syt_accum
    import cip_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reload_i,
    input  logic              advance_i,
    input  logic [STEP_W-1:0] step_int_i,
    input  logic [REM_W-1:0]  step_rem_i,
    input  logic [REM_W-1:0]  rate_i,
    output logic [CYC_W-1:0]  cycle_o,
    output logic [OFF_W-1:0]  offset_o
);
    localparam int SUM_W    = STEP_W + 1;
    localparam int MAX_WRAP = int'((TICKS_PER_CYCLE - 1 + (1 << STEP_W)) / TICKS_PER_CYCLE);

    typedef struct packed {
        logic [CYC_W-1:0] cyc;
        logic [OFF_W-1:0] off;
        logic [REM_W-1:0] rem;
    } acc_t;

    localparam acc_t ACC_INIT = '{cyc: CYC_W'(INIT_CYCLE), off: OFF_W'(INIT_OFFSET), rem: '0};

    acc_t acc_d, acc_q;
    logic [REM_W:0]   rem_sum;
    logic             carry;
    logic [REM_W-1:0] rem_next;
    logic [SUM_W-1:0] int_sum;
    logic [CYC_W-1:0] wraps;
    logic [OFF_W-1:0] off_next;

    always_comb begin
        rem_sum  = {1'b0, acc_q.rem} + {1'b0, step_rem_i};
        carry    = rem_sum >= {1'b0, rate_i};
        rem_next = carry ? REM_W'(rem_sum - {1'b0, rate_i}) : REM_W'(rem_sum);
        int_sum  = SUM_W'(acc_q.off) + SUM_W'(step_int_i) + SUM_W'(carry);
        wraps    = '0;
        for (int k = MAX_WRAP; k >= 1; k--) begin
            if (wraps == '0 && int_sum >= SUM_W'(k * int'(TICKS_PER_CYCLE)))
                wraps = CYC_W'(k);
        end
        off_next = OFF_W'(int_sum - SUM_W'(wraps) * SUM_W'(TICKS_PER_CYCLE));

        acc_d = acc_q;
        if (reload_i) begin
            acc_d = ACC_INIT;
        end else if (advance_i) begin
            acc_d.cyc = acc_q.cyc + wraps;
            acc_d.off = off_next;
            acc_d.rem = rem_next;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) acc_q <= ACC_INIT;
        else        acc_q <= acc_d;
    end

    assign cycle_o  = acc_q.cyc;
    assign offset_o = acc_q.off;

    p_offset_range_r6: assert property (@(posedge clk) disable iff (!rst_n)
        acc_q.off < OFF_W'(TICKS_PER_CYCLE) && acc_q.rem < rate_i);
    p_reload_init_r9: assert property (@(posedge clk) disable iff (!rst_n)
        reload_i |=> acc_q.cyc == CYC_W'(INIT_CYCLE) && acc_q.off == OFF_W'(INIT_OFFSET) && acc_q.rem == '0);
    p_idle_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (!reload_i && !advance_i) |=> $stable(acc_q));
    p_advance_moves_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (advance_i && !reload_i) |=> (acc_q.cyc != $past(acc_q.cyc) || acc_q.off != $past(acc_q.off)));
endmodule

// File: rtl/cip_hdr_gen.sv
module cip_hdr_gen
    import cip_pkg::*;
#(
    parameter int EVT_W = 8,
    localparam int SIZE_W = EVT_W + DIM_W + 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_load_i,
    input  logic [CODE_W-1:0] cfg_code_i,
    input  logic [DIM_W-1:0]  cfg_dim_i,
    input  logic [SID_W-1:0]  node_id_i,
    input  logic              pkt_start_i,
    input  logic [EVT_W-1:0]  pkt_events_i,
    output logic              hdr_valid_o,
    output logic [31:0]       hdr_q0_o,
    output logic [31:0]       hdr_q1_o,
    output logic [SIZE_W-1:0] pkt_bytes_o
);
    localparam int CMP_W = (EVT_W > DBC_W) ? EVT_W : DBC_W;

    typedef struct packed {
        logic [CODE_W-1:0] code;
        logic [DIM_W-1:0]  dim;
        logic [DBC_W-1:0]  dbc;
        logic              vld;
        logic [31:0]       q0;
        logic [31:0]       q1;
        logic [SIZE_W-1:0] bytes;
    } hdr_st_t;

    hdr_st_t st_d, st_q;

    logic [IVL_W-1:0]  ivl;
    logic [STEP_W-1:0] step_int;
    logic [REM_W-1:0]  step_rem;
    logic [REM_W-1:0]  rate;
    logic [CYC_W-1:0]  acc_cyc;
    logic [OFF_W-1:0]  acc_off;
    logic              cfg_ok;
    logic              stamp;
    logic [DBC_W-1:0]  ivl_ext;
    logic [DBC_W-1:0]  ts_idx;
    logic [15:0]       syt;

    cip_rate_table u_rate (
        .code_i     (st_q.code),
        .ivl_o      (ivl),
        .step_int_o (step_int),
        .step_rem_o (step_rem),
        .rate_o     (rate)
    );

    cip_syt_accum u_accum (
        .clk        (clk),
        .rst_n      (rst_n),
        .reload_i   (cfg_ok),
        .advance_i  (stamp),
        .step_int_i (step_int),
        .step_rem_i (step_rem),
        .rate_i     (rate),
        .cycle_o    (acc_cyc),
        .offset_o   (acc_off)
    );

    assign cfg_ok = cfg_load_i && (cfg_code_i < CODE_W'(RATE_CODES));

    always_comb begin
        st_d     = st_q;
        st_d.vld = pkt_start_i;
        ivl_ext  = DBC_W'(ivl);
        ts_idx   = (ivl_ext - st_q.dbc) & (ivl_ext - DBC_W'(1));
        stamp    = 1'b0;
        syt      = 16'hFFFF;
        if (pkt_start_i) begin
            stamp      = CMP_W'(ts_idx) < CMP_W'(pkt_events_i);
            if (stamp) syt = {acc_cyc, acc_off};
            st_d.q0    = {EOH_FIRST, node_id_i, st_q.dim, 8'h00, st_q.dbc};
            st_d.q1    = {EOH_SECOND, FMT_AUDIO, 8'(st_q.code), syt};
            st_d.bytes = (SIZE_W'(pkt_events_i) * SIZE_W'(st_q.dim) + SIZE_W'(2)) << 2;
            st_d.dbc   = st_q.dbc + DBC_W'(pkt_events_i);
        end
        if (cfg_ok) begin
            st_d.code = cfg_code_i;
            st_d.dim  = cfg_dim_i;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q      <= '0;
            st_q.code <= DEFAULT_CODE;
            st_q.dim  <= DEFAULT_DIM;
        end else begin
            st_q <= st_d;
        end
    end

    assign hdr_valid_o = st_q.vld;
    assign hdr_q0_o    = st_q.q0;
    assign hdr_q1_o    = st_q.q1;
    assign pkt_bytes_o = st_q.bytes;

    p_valid_after_start_r1: assert property (@(posedge clk) disable iff (!rst_n)
        pkt_start_i |=> hdr_valid_o);
    p_valid_needs_start_r1: assert property (@(posedge clk) disable iff (!rst_n)
        hdr_valid_o |-> $past(pkt_start_i));
    p_dbc_advance_r8: assert property (@(posedge clk) disable iff (!rst_n)
        pkt_start_i |=> st_q.dbc == $past(st_q.dbc + DBC_W'(pkt_events_i)));
    p_bad_code_ignored_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_load_i && cfg_code_i >= CODE_W'(RATE_CODES)) |=> ($stable(st_q.code) && $stable(st_q.dim)));
    p_stamp_offset_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (hdr_valid_o && hdr_q1_o[15:0] != 16'hFFFF) |-> hdr_q1_o[11:0] < 12'(TICKS_PER_CYCLE));
    p_second_quadlet_r3: assert property (@(posedge clk) disable iff (!rst_n)
        hdr_valid_o |-> (hdr_q1_o[31:24] == 8'h90 && hdr_q1_o[23:16] < 8'(RATE_CODES)));
endmodule

// File: tb/tb_cip_hdr_gen.sv
`timescale 1ns/1ps
module tb_cip_hdr_gen;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_load = 1'b0;
    logic [2:0]  cfg_code = '0;
    logic [7:0]  cfg_dim = '0;
    logic [5:0]  node_id = '0;
    logic        pkt_start = 1'b0;
    logic [7:0]  pkt_events = '0;
    logic        hdr_valid;
    logic [31:0] hdr_q0, hdr_q1;
    logic [18:0] pkt_bytes;

    always #2.5 clk = ~clk;

    cip_hdr_gen dut (
        .clk(clk), .rst_n(rst_n), .cfg_load_i(cfg_load), .cfg_code_i(cfg_code),
        .cfg_dim_i(cfg_dim), .node_id_i(node_id), .pkt_start_i(pkt_start),
        .pkt_events_i(pkt_events), .hdr_valid_o(hdr_valid), .hdr_q0_o(hdr_q0),
        .hdr_q1_o(hdr_q1), .pkt_bytes_o(pkt_bytes)
    );

    int checks = 0;
    int fails = 0;
    bit done = 0;
    string phase = "R7";

    int m_code, m_dim, m_dbc, m_cyc, m_offi;
    longint m_offr;

    function automatic int rate_of(input int c);
        int hz[7] = '{32000, 44100, 48000, 88200, 96000, 176400, 192000};
        return hz[c];
    endfunction
    function automatic int ivl_of(input int c);
        return (c <= 2) ? 8 : (c <= 4) ? 16 : 32;
    endfunction

    task automatic model_reset();
        m_code = 2; m_dim = 2; m_dbc = 0; m_cyc = 2; m_offi = 2856; m_offr = 0;
    endtask

    task automatic check(input string req, input longint act, input longint exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s [%s] actual=%0h expected=%0h", req, phase, act, exp);
        end
    endtask

    task automatic cyc(input bit rst, input bit start, input int ev,
                       input bit cfg, input int code, input int dim, input int nid);
        logic [31:0] e0, e1;
        int ebytes, iv, idx, syt;
        longint num, r;
        bit stamp, ev_v;
        @(negedge clk);
        rst_n = !rst; pkt_start = start; pkt_events = 8'(ev);
        cfg_load = cfg; cfg_code = 3'(code); cfg_dim = 8'(dim); node_id = 6'(nid);
        @(posedge clk);
        #1;
        ev_v = 0; e0 = '0; e1 = '0; ebytes = 0;
        if (rst) begin
            model_reset();
        end else begin
            if (start) begin
                ev_v = 1;
                iv = ivl_of(m_code);
                idx = (iv - m_dbc) & (iv - 1);
                stamp = idx < ev;
                syt = stamp ? (((m_cyc % 16) << 12) | m_offi) : 'hFFFF;
                e0 = {2'b00, 6'(nid), 8'(m_dim), 8'h00, 8'(m_dbc)};
                e1 = {2'b10, 6'h10, 8'(m_code), 16'(syt)};
                ebytes = (ev * m_dim + 2) * 4;
                if (stamp) begin
                    r = rate_of(m_code);
                    num = 64'd24576000 * iv;
                    m_offr += num % r;
                    m_offi += int'(num / r + m_offr / r);
                    m_offr = m_offr % r;
                    m_cyc += m_offi / 3072;
                    m_offi = m_offi % 3072;
                end
                m_dbc = (m_dbc + ev) % 256;
            end
            if (cfg && code < 7) begin
                m_code = code; m_dim = dim; m_cyc = 2; m_offi = 2856; m_offr = 0;
            end
        end
        check("R1 valid", hdr_valid, ev_v);
        if (ev_v) begin
            check("R2 quadlet0", hdr_q0, e0);
            check("R3 R4 quadlet1 tag", hdr_q1[31:16], e1[31:16]);
            check("R5 R6 timestamp", hdr_q1[15:0], e1[15:0]);
            check("R8 bytes", pkt_bytes, ebytes);
        end
    endtask

    task automatic pkt(input int ev, input int nid);
        cyc(0, 1, ev, 0, 0, 0, nid);
    endtask
    task automatic cfgw(input int code, input int dim);
        cyc(0, 0, 0, 1, code, dim, 0);
    endtask
    task automatic idle();
        cyc(0, 0, 0, 0, 0, 0, 0);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            checks++; fails++;
            $display("FAIL watchdog expired [%s] actual=hung expected=finish", phase);
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        model_reset();
        // R7: reset state, then first packet carries 0x2B28 with dbc 0
        repeat (3) cyc(1, 0, 0, 0, 0, 0, 0);
        idle();
        phase = "R7 first";
        pkt(6, 6'h2A);
        check("R7 first stamp", hdr_q1[15:0], 16'h2B28);
        // R1 R2 R5: 48k, dim 2, with gaps
        phase = "R1 R2 48k";
        for (int i = 0; i < 40; i++) begin
            pkt(6, i);
            if (i % 3 == 0) idle();
        end
        // R6: 44.1k fractional carry over many stamps
        phase = "R6 R9 44k1";
        cfgw(1, 2);
        for (int i = 0; i < 200; i++) pkt((i % 80 < 41) ? 6 : 5, 3);
        // R4: code 7 write ignored
        phase = "R4 bad code";
        cfgw(7, 5);
        pkt(6, 1);
        check("R4 dim kept", hdr_q0[23:16], 8'd2);
        check("R4 rate kept", hdr_q1[23:16], 8'd1);
        // R5 R8: interval 16, blocking style with empty packets
        phase = "R5 R8 96k";
        cfgw(4, 4);
        for (int i = 0; i < 30; i++) pkt((i % 2) ? 0 : 16, 9);
        pkt(0, 9);
        check("R5 empty no stamp", hdr_q1[15:0], 16'hFFFF);
        check("R8 empty size", pkt_bytes, 19'd8);
        // 192k, interval 32
        phase = "R4 R6 192k";
        cfgw(6, 10);
        for (int i = 0; i < 40; i++) pkt(24 + (i % 9), 12);
        // R8: counter wrap at 256
        phase = "R8 wrap";
        cfgw(0, 1);
        for (int i = 0; i < 6; i++) pkt(200, 5);
        // R10: write and start in the same cycle
        phase = "R10 collision";
        pkt(7, 2);
        cyc(0, 1, 7, 1, 3, 3, 2);
        check("R10 old rate used", hdr_q1[23:16], 8'd0);
        pkt(5, 2);
        check("R10 new rate after", hdr_q1[23:16], 8'd3);
        for (int i = 0; i < 20; i++) pkt(8 + (i % 11), 2);
        // R9: writes between packets keep dbc
        phase = "R9 reload";
        for (int i = 0; i < 300; i++) begin
            if (i % 50 == 25) cfgw((i / 50) % 7, 1 + (i % 5));
            pkt((i * 37) % 23, i % 64);
            if (i % 7 == 0) idle();
        end
        // R7: reset in mid stream
        phase = "R7 mid reset";
        cyc(1, 1, 9, 0, 0, 0, 0);
        idle();
        pkt(3, 1);
        check("R7 dbc cleared", hdr_q0[7:0], 8'd0);
        for (int i = 0; i < 20; i++) pkt(i % 9, 4);
        idle();
        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule